// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM

This block models a synchronous burst cache memory with a 32-bit word, built from four byte lanes. The word address width is a parameter. A new access begins on a rising clock edge where either of two active-low address strobes is asserted. One strobe serves a processor and the other serves a cache controller. On that edge the block captures the external address together with three chip selects. After that, an internal two-bit counter supplies the low two address bits for the remaining beats of a four-beat burst. An advance input steps the counter, and leaving it high suspends the burst. A mode pin selects linear or interleaved beat order.

Reads are flow-through. The word at the registered address appears on the read port in the same cycle that follows the capturing edge, with no output register, which gives a 2-1-1-1 access pattern. Writes can cover any subset of byte lanes, or the whole word through a global write input. A write leaves the read port disabled until a strobe starts a new read. The output-enable input gates the read port combinationally, without waiting for a clock edge. The bidirectional data bus is split into a write-data input, a read-data output and a drive flag.

Top module: `fts_burst_sram`

## Requirements
- R1: A rising edge with `ctrl_stb_n` low, or with `proc_stb_n` low while `sel1_n` is low, captures `addr_i` and the three selects and starts a burst whose first beat is the address `addr_i`.
- R2: While `sel1_n` is high, a low `proc_stb_n` has no effect: the burst address and read data stay as they were.
- R3: The block is selected only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0 on the capturing edge. A strobe edge with any other select combination deselects the block: the read port is disabled, and later edges neither advance nor write until a new strobe arrives.
- R4: Beat k (k=0..3) of a burst starting at low bits s uses low bits (s+k) mod 4 when `order_ilv`=0, and s XOR k when `order_ilv`=1. The upper address bits stay fixed, and the sequence wraps.
- R5: On an edge without a valid strobe, `adv_n`=0 steps the beat counter by one and `adv_n`=1 holds the current address.
- R6: A valid strobe in the middle of a burst loads the new external address and restarts at beat 0.
- R7: Byte lane i is bits [8i+7:8i]. A write edge writes lane i when `glob_wr_n`=0, or when `byte_wr_en_n`=0 and `byte_en_n[i]`=0. With `byte_wr_en_n`=1 and `glob_wr_n`=1 nothing is written, whatever `byte_en_n` holds.
- R8: On an edge where the processor strobe is valid, the write inputs are ignored and the cycle is a read. On a non-strobe edge of a selected burst, a write goes to the address after that edge's step or hold. On a controller-strobe edge, a write goes to `addr_i`.
- R9: After an edge, `rdata_o` shows the stored word at the current burst address in the same cycle, with no extra register stage.
- R10: `rdata_oe_o` is 1 only when `oe_n` is 0, the block is selected and a read is active, and it follows `oe_n` without a clock edge. `rdata_o` is 0 whenever `rdata_oe_o` is 0. Reset leaves `rdata_oe_o` at 0.
- R11: After a write edge, `rdata_oe_o` stays 0 through further non-strobe edges, until a strobe edge that does not write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the burst control state |
| addr_i | input | ADDR_W | External word address |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| sel1_n | input | 1 | Chip select 1, active low; also qualifies the processor strobe |
| sel2 | input | 1 | Chip select 2, active high |
| sel3_n | input | 1 | Chip select 3, active low |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| glob_wr_n | input | 1 | Global write of all lanes, active low |
| byte_wr_en_n | input | 1 | Byte-write enable, active low |
| byte_en_n | input | 4 | Per-lane write selects, active low |
| wdata_i | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata_o | output | 32 | Flow-through read data, 0 when not driven |
| rdata_oe_o | output | 1 | Read data is being driven |

## Verification
The bench builds the block with `ADDR_W`=4, so the array holds 16 words in four burst groups. This makes it practical to fill every word and to run a burst from every start address in both orders, with each beat's address derived arithmetically in the bench. The small array also allows a sweep of all 16 byte-enable patterns, and lets deselected and processor-strobe write attempts be checked against a full shadow copy of memory.

// File: rtl/fts_pkg.sv
package fts_pkg;

    // Burst control state, registered each clock.
    typedef struct packed {
        logic       act;     // block selected by last strobe
        logic       rd_en;   // read port may drive
        logic [1:0] start;   // low address bits of first beat
        logic [1:0] cnt;     // beat count since start
    } ctl_t;

    // Low address bits for beat k of a burst starting at s.
    function automatic logic [1:0] burst_lo(input logic [1:0] s,
                                            input logic [1:0] k,
                                            input logic       ilv);
        logic [1:0] lin;
        lin = s + k;
        return ilv ? (s ^ k) : lin;
    endfunction

endpackage

// File: rtl/fts_sel_dec.sv
module fts_sel_dec (
    input  logic proc_stb_n,
    input  logic ctrl_stb_n,
    input  logic sel1_n,
    input  logic sel2,
    input  logic sel3_n,
    output logic load,
    output logic proc_cyc,
    output logic chip_on
);
    // Processor strobe counts only while select 1 is asserted.
    assign proc_cyc = !proc_stb_n && !sel1_n;
    assign load     = proc_cyc || !ctrl_stb_n;
    assign chip_on  = !sel1_n && sel2 && !sel3_n;
endmodule

// File: rtl/fts_wr_dec.sv
module fts_wr_dec #(
    parameter int LANES = 4
) (
    input  logic             glob_wr_n,
    input  logic             byte_wr_en_n,
    input  logic [LANES-1:0] byte_en_n,
    output logic [LANES-1:0] lane_we
);
    always_comb begin
        if (!glob_wr_n)         lane_we = '1;
        else if (!byte_wr_en_n) lane_we = ~byte_en_n;
        else                    lane_we = '0;
    end
endmodule

// File: rtl/fts_burst_seq.sv
module fts_burst_seq (
    input  logic [1:0] start,
    input  logic [1:0] cnt,
    input  logic       ilv,
    input  logic       step,
    output logic [1:0] cur_lo,
    output logic [1:0] nxt_cnt,
    output logic [1:0] nxt_lo
);
    import fts_pkg::*;

    assign nxt_cnt = cnt + {1'b0, step};
    assign cur_lo  = burst_lo(start, cnt, ilv);
    assign nxt_lo  = burst_lo(start, nxt_cnt, ilv);
endmodule

// File: rtl/fts_mem_array.sv
module fts_mem_array #(
    parameter int ADDR_W = 9,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        we,
    input  logic [ADDR_W-1:0]       waddr,
    input  logic [LANES*LANE_W-1:0] wdata,
    input  logic [ADDR_W-1:0]       raddr,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        // Flow-through: no read register.
        assign rdata[g*LANE_W +: LANE_W] = mem[raddr];
    end
endmodule

// File: rtl/fts_burst_sram.sv
module fts_burst_sram #(
    parameter int ADDR_W = 9,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    proc_stb_n,
    input  logic                    ctrl_stb_n,
    input  logic                    adv_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    order_ilv,
    input  logic                    glob_wr_n,
    input  logic                    byte_wr_en_n,
    input  logic [LANES-1:0]        byte_en_n,
    input  logic [LANES*LANE_W-1:0] wdata_i,
    input  logic                    oe_n,
    output logic [LANES*LANE_W-1:0] rdata_o,
    output logic                    rdata_oe_o
);
    import fts_pkg::*;

    localparam int DATA_W = LANES * LANE_W;
    localparam int BASE_W = ADDR_W - 2;

    ctl_t              ctl_d, ctl_q;
    logic [BASE_W-1:0] base_d, base_q;

    logic              load, proc_cyc, chip_on;
    logic [LANES-1:0]  lane_we;
    logic [1:0]        cur_lo, nxt_cnt, nxt_lo;
    logic [LANES-1:0]  mem_we;
    logic [ADDR_W-1:0] wr_addr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] mem_rdata;
    logic              burst_act;

    fts_sel_dec u_sel (
        .proc_stb_n (proc_stb_n),
        .ctrl_stb_n (ctrl_stb_n),
        .sel1_n     (sel1_n),
        .sel2       (sel2),
        .sel3_n     (sel3_n),
        .load       (load),
        .proc_cyc   (proc_cyc),
        .chip_on    (chip_on)
    );

    fts_wr_dec #(.LANES(LANES)) u_wr (
        .glob_wr_n    (glob_wr_n),
        .byte_wr_en_n (byte_wr_en_n),
        .byte_en_n    (byte_en_n),
        .lane_we      (lane_we)
    );

    fts_burst_seq u_seq (
        .start   (ctl_q.start),
        .cnt     (ctl_q.cnt),
        .ilv     (order_ilv),
        .step    (!adv_n),
        .cur_lo  (cur_lo),
        .nxt_cnt (nxt_cnt),
        .nxt_lo  (nxt_lo)
    );

    assign rd_addr   = {base_q, cur_lo};
    assign burst_act = ctl_q.act;

    always_comb begin
        ctl_d   = ctl_q;
        base_d  = base_q;
        mem_we  = '0;
        wr_addr = {base_q, nxt_lo};
        if (load) begin
            ctl_d.act   = chip_on;
            ctl_d.rd_en = chip_on;
            ctl_d.start = addr_i[1:0];
            ctl_d.cnt   = 2'd0;
            base_d      = addr_i[ADDR_W-1:2];
            wr_addr     = addr_i;
            // Processor-strobe edges are always reads.
            if (chip_on && !proc_cyc && (|lane_we)) begin
                mem_we      = lane_we;
                ctl_d.rd_en = 1'b0;
            end
        end else if (ctl_q.act) begin
            ctl_d.cnt = nxt_cnt;
            if (|lane_we) begin
                mem_we      = lane_we;
                ctl_d.rd_en = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            base_q <= '0;
        end else begin
            ctl_q  <= ctl_d;
            base_q <= base_d;
        end
    end

    fts_mem_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (wr_addr),
        .wdata (wdata_i),
        .raddr (rd_addr),
        .rdata (mem_rdata)
    );

    assign rdata_oe_o = !oe_n && ctl_q.act && ctl_q.rd_en;
    assign rdata_o    = rdata_oe_o ? mem_rdata : '0;
endmodule

// File: rtl/fts_burst_sram_chk.sv
module fts_burst_sram_chk #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              proc_stb_n,
    input logic              ctrl_stb_n,
    input logic              adv_n,
    input logic              sel1_n,
    input logic              sel2,
    input logic              sel3_n,
    input logic              order_ilv,
    input logic              glob_wr_n,
    input logic              oe_n,
    input logic              rdata_oe_o,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              burst_act
);
    logic sel_ok;
    assign sel_ok = !sel1_n && sel2 && !sel3_n;

    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_oe_o);

    p_write_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stb_n && proc_stb_n && sel_ok && !glob_wr_n) |=> !rdata_oe_o);

    p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_stb_n && !sel_ok) |=> (!rdata_oe_o && !burst_act));

    p_proc_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_stb_n && sel_ok) |=> (oe_n || rdata_oe_o));

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && adv_n && proc_stb_n && ctrl_stb_n) |=> $stable(rd_addr));

    p_ignore_proc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && !proc_stb_n && sel1_n && ctrl_stb_n && adv_n) |=> $stable(rd_addr));

    p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && !adv_n && proc_stb_n && ctrl_stb_n && !order_ilv) |=>
        (order_ilv || ((rd_addr[1:0] == $past(rd_addr[1:0]) + 2'd1) &&
                       (rd_addr[ADDR_W-1:2] == $past(rd_addr[ADDR_W-1:2])))));
endmodule

bind fts_burst_sram fts_burst_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .adv_n      (adv_n),
    .sel1_n     (sel1_n),
    .sel2       (sel2),
    .sel3_n     (sel3_n),
    .order_ilv  (order_ilv),
    .glob_wr_n  (glob_wr_n),
    .oe_n       (oe_n),
    .rdata_oe_o (rdata_oe_o),
    .rd_addr    (rd_addr),
    .burst_act  (burst_act)
);

// File: tb/fts_burst_sram_bench.sv
module fts_burst_sram_bench;
    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          proc_stb_n = 1'b1, ctrl_stb_n = 1'b1, adv_n = 1'b1;
    logic          sel1_n = 1'b0, sel2 = 1'b1, sel3_n = 1'b0;
    logic          order_ilv = 1'b0, glob_wr_n = 1'b1, byte_wr_en_n = 1'b1;
    logic [3:0]    byte_en_n = 4'hF;
    logic [31:0]   wdata_i = '0;
    logic          oe_n = 1'b0;
    logic [31:0]   rdata_o;
    logic          rdata_oe_o;

    logic [31:0]   exp_mem [NW];
    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;

    fts_burst_sram #(.ADDR_W(AW)) u_fts_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
        .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n), .order_ilv(order_ilv),
        .glob_wr_n(glob_wr_n), .byte_wr_en_n(byte_wr_en_n), .byte_en_n(byte_en_n),
        .wdata_i(wdata_i), .oe_n(oe_n), .rdata_o(rdata_o), .rdata_oe_o(rdata_oe_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [1:0] seq(input logic [1:0] s, input int k, input logic ilv);
        logic [1:0] kk;
        kk = 2'(k);
        return ilv ? (s ^ kk) : 2'((int'(s) + k) % 4);
    endfunction

    function automatic logic [31:0] pat(input int a, input int salt);
        return 32'hC3A5_0000 ^ (32'(a) * 32'h0101_0107) ^ 32'(salt);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #5;
    endtask

    task automatic idle();
        proc_stb_n = 1'b1; ctrl_stb_n = 1'b1; adv_n = 1'b1;
        glob_wr_n = 1'b1; byte_wr_en_n = 1'b1; byte_en_n = 4'hF;
        sel1_n = 1'b0; sel2 = 1'b1; sel3_n = 1'b0;
    endtask

    task automatic wr_word(input int a, input logic [31:0] d);
        idle();
        ctrl_stb_n = 1'b0; addr_i = AW'(a); glob_wr_n = 1'b0; wdata_i = d;
        cyc();
        exp_mem[a] = d;
        idle();
        chk("R11 output off after write", 32'(rdata_oe_o), 32'd0);
    endtask

    task automatic rd1(input int a, output logic [31:0] d);
        idle();
        proc_stb_n = 1'b0; addr_i = AW'(a);
        cyc();
        idle();
        d = rdata_o;
    endtask

    task automatic rd_burst(input int a, input logic ilv);
        idle();
        order_ilv = ilv;
        proc_stb_n = 1'b0; addr_i = AW'(a);
        cyc();
        proc_stb_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            int ea;
            if (k > 0) begin adv_n = 1'b0; cyc(); end
            ea = (a & ~3) | int'(seq(2'(a), k, ilv));
            chk("R9 read drives", 32'(rdata_oe_o), 32'd1);
            chk(ilv ? "R4 interleaved beat" : "R4 linear beat", rdata_o, exp_mem[ea]);
        end
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        idle();
        repeat (3) cyc();
        chk("R10 reset output off", 32'(rdata_oe_o), 32'd0);
        chk("R10 reset data zero", rdata_o, 32'd0);
        rst_n = 1'b1;
        cyc();

        // Fill the whole array, then sweep every start in both orders (R1, R4, R9).
        for (int a = 0; a < NW; a++) wr_word(a, pat(a, 0));
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < NW; a++) rd_burst(a, 1'(m));

        // R11: non-strobe read edge after a write keeps the port off.
        wr_word(5, pat(5, 7));
        adv_n = 1'b0; cyc(); idle();
        chk("R11 still off after continuation", 32'(rdata_oe_o), 32'd0);
        proc_stb_n = 1'b0; addr_i = 4'd5; cyc(); idle();
        chk("R11 strobe read re-enables", 32'(rdata_oe_o), 32'd1);
        chk("R9 data after re-enable", rdata_o, exp_mem[5]);

        // R10: output enable acts without a clock edge.
        oe_n = 1'b1; #1;
        chk("R10 async disable", 32'(rdata_oe_o), 32'd0);
        chk("R10 data zero when off", rdata_o, 32'd0);
        oe_n = 1'b0; #1;
        chk("R10 async enable", rdata_o, exp_mem[5]);

        // R5: suspend holds, then step.
        order_ilv = 1'b0;
        proc_stb_n = 1'b0; addr_i = 4'd5; cyc(); idle();
        repeat (2) begin
            cyc();
            chk("R5 suspend holds", rdata_o, exp_mem[5]);
        end
        adv_n = 1'b0; cyc(); idle();
        chk("R5 advance steps", rdata_o, exp_mem[6]);

        // R2: processor strobe ignored with select 1 high.
        proc_stb_n = 1'b0; addr_i = 4'd8; cyc(); idle();
        sel1_n = 1'b1; proc_stb_n = 1'b0; addr_i = 4'd3; cyc(); idle();
        chk("R2 proc strobe ignored", rdata_o, exp_mem[8]);
        adv_n = 1'b0; cyc(); idle();
        chk("R2 burst continues", rdata_o, exp_mem[9]);

        // R6: new strobe mid-burst restarts.
        proc_stb_n = 1'b0; addr_i = 4'd0; cyc(); idle();
        adv_n = 1'b0; cyc(); idle();
        ctrl_stb_n = 1'b0; addr_i = 4'd13; cyc(); idle();
        chk("R6 restart loads new address", rdata_o, exp_mem[13]);
        adv_n = 1'b0; cyc(); idle();
        chk("R6 restart beat 1", rdata_o, exp_mem[14]);

        // R3: deselect by each select; later write edges do nothing.
        for (int s = 0; s < 3; s++) begin
            ctrl_stb_n = 1'b0; addr_i = 4'd2;
            if (s == 0) sel2 = 1'b0;
            if (s == 1) sel3_n = 1'b1;
            if (s == 2) sel1_n = 1'b1;
            cyc(); idle();
            chk("R3 deselect disables output", 32'(rdata_oe_o), 32'd0);
            glob_wr_n = 1'b0; adv_n = 1'b0; wdata_i = 32'hFFFF_FFFF;
            repeat (2) cyc();
            idle();
            chk("R3 deselected stays off", 32'(rdata_oe_o), 32'd0);
        end
        rd_burst(0, 1'b0);

        // R8: processor-strobe edge ignores writes; continuation edges write.
        order_ilv = 1'b0;
        proc_stb_n = 1'b0; addr_i = 4'd6; glob_wr_n = 1'b0; wdata_i = 32'hDEAD_0000;
        cyc(); idle();
        chk("R8 proc edge is a read", 32'(rdata_oe_o), 32'd1);
        chk("R8 proc edge no write", rdata_o, exp_mem[6]);
        glob_wr_n = 1'b0; wdata_i = pat(6, 1); cyc();
        exp_mem[6] = pat(6, 1);
        adv_n = 1'b0; wdata_i = pat(7, 1); cyc();
        exp_mem[7] = pat(7, 1);
        wdata_i = pat(4, 1); cyc();
        exp_mem[4] = pat(4, 1);
        idle();
        chk("R11 burst write keeps output off", 32'(rdata_oe_o), 32'd0);
        rd_burst(6, 1'b0);

        // R7: all byte-enable patterns, plus disabled byte writes.
        for (int m = 0; m < 16; m++) begin
            logic [31:0] e;
            wr_word(9, 32'h0);
            ctrl_stb_n = 1'b0; addr_i = 4'd9; byte_wr_en_n = 1'b0;
            byte_en_n = 4'(m); wdata_i = 32'hFFFF_FFFF;
            cyc(); idle();
            for (int i = 0; i < 4; i++) e[i*8 +: 8] = m[i] ? 8'h00 : 8'hFF;
            exp_mem[9] = e;
            rd1(9, d);
            chk("R7 byte lanes", d, e);
        end
        ctrl_stb_n = 1'b0; addr_i = 4'd9; byte_en_n = 4'h0; wdata_i = 32'h1234_5678;
        cyc(); idle();
        rd1(9, d);
        chk("R7 byte enables without byte-write enable", d, exp_mem[9]);
        ctrl_stb_n = 1'b0; addr_i = 4'd9; glob_wr_n = 1'b0; byte_en_n = 4'hF;
        wdata_i = 32'h1234_5678;
        cyc(); idle();
        exp_mem[9] = 32'h1234_5678;
        rd1(9, d);
        chk("R7 global write all lanes", d, exp_mem[9]);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule